// File: doc/BRIEF.md
# Data Lane Start/End-of-Transmission Sequencer

This block moves a single serial data lane between its low-power idle level and a high-speed burst, and back again. When a burst is requested, it drives the two single-ended low-power lines through the request state (LP-01) and the bridge state (LP-00). It then enables the high-speed driver, sends zeros, then a sync byte, and then streams payload bytes taken from the caller while a ready flag is high. After the last byte it holds a trailer level. It then returns to LP-11 and enforces a minimum gap before it starts the next entry.

Every phase length comes from fields packed into three 32-bit timing words, counted in byte-clock cycles. The words are copied into shadow registers only while the lane sits idle, so a burst that is already running always finishes with the values it started with. The clock-lane fields in the middle word are decoded and brought out for a neighbouring clock-lane block. The data lane does not use them.

Top module: `hs_lane_seq`

## Requirements
- R1: After reset, and whenever idle, the lane shows LP-11 (`lp_p`=1, `lp_n`=1) with `hs_en`=0 and `tx_ready`=0. The line pair never shows `lp_p`=1 with `lp_n`=0.
- R2: A burst always passes LP-11, LP-01 (`lp_p`=0, `lp_n`=1), LP-00 (both 0), high-speed zero, sync and payload in that order. No state is skipped or merged, whatever the field values.
- R3: LP-01 lasts the count in bits [11:8] of `tim_entry`, in cycles.
- R4: LP-00 lasts the count in bits [7:0] of `tim_burst`. High-speed zero (`hs_en`=1, `hs_byte`=0x00) then lasts the count in bits [15:8] of `tim_burst`.
- R5: A field value of zero gives a phase of exactly one cycle. This applies to LP-01, LP-00, zero, trailer and exit gap alike.
- R6: The sync byte 0xB8 is driven for one cycle after the zero period. `tx_ready` then rises, and `hs_byte` equals `tx_data` in each ready cycle. The payload ends with the cycle in which `tx_last` is high.
- R7: After the payload, `hs_en` stays high for the count in bits [19:16] of `tim_burst`. During that time every bit of `hs_byte` is the inverse of bit 7 of the last payload byte.
- R8: After the trailer the lane returns to LP-11 with `hs_en` low. LP-01 comes no earlier than (bits [7:0] of `tim_entry`) + 1 cycles later. A request made during that gap is held, and it starts LP-01 exactly at that point.
- R9: Changes to the timing words during a burst do not affect that burst. They take effect from the next entry made from idle.
- R10: `clk_prep_cnt`, `clk_zero_cnt`, `clk_post_cnt` and `clk_trail_cnt` present bits [31:24], [23:16], [15:8] and [7:0] of the shadowed `tim_clk`.
- R11: A request raised while a burst is between LP-01 and the end of the trailer is ignored and starts no further burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tim_entry | input | 32 | Timing word: LP-01 length [11:8], exit gap [7:0] |
| tim_clk | input | 32 | Clock-lane timing word, decoded only |
| tim_burst | input | 32 | Timing word: trailer [19:16], zero [15:8], LP-00 [7:0] |
| req | input | 1 | Request a high-speed burst |
| tx_data | input | 8 | Payload byte, taken when `tx_ready` is high |
| tx_last | input | 1 | Marks the current payload byte as the last |
| lp_p | output | 1 | Positive-line low-power level |
| lp_n | output | 1 | Negative-line low-power level |
| hs_en | output | 1 | High-speed driver enable |
| hs_byte | output | 8 | Byte to the serialiser |
| tx_ready | output | 1 | Payload may flow this cycle |
| clk_prep_cnt | output | 8 | Shadowed clock-lane prepare count |
| clk_zero_cnt | output | 8 | Shadowed clock-lane zero count |
| clk_post_cnt | output | 8 | Shadowed clock-lane post count |
| clk_trail_cnt | output | 8 | Shadowed clock-lane trail count |

## Verification
The exit gap and idle look identical on the lines, so the held request is the hardest case to expose. The stimulus pulses `req` for a single cycle right after the trailer ends. It then counts the LP-11 cycles until LP-01 appears, which must be the exit count plus one. A second hard case is a register write in the middle of a burst. The bench changes all three words and pulses `req` during the first payload byte. It then confirms that the rest of that burst uses the old trailer length and the old clock fields, that no extra burst starts, and that the next burst uses the new lengths.

// File: rtl/hs_lane_seq.sv
module hs_lane_seq #(
  parameter int CW = 8,
  parameter logic [7:0] SYNC_BYTE = 8'hB8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] tim_entry,
  input  logic [31:0] tim_clk,
  input  logic [31:0] tim_burst,
  input  logic        req,
  input  logic [7:0]  tx_data,
  input  logic        tx_last,
  output logic        lp_p,
  output logic        lp_n,
  output logic        hs_en,
  output logic [7:0]  hs_byte,
  output logic        tx_ready,
  output logic [7:0]  clk_prep_cnt,
  output logic [7:0]  clk_zero_cnt,
  output logic [7:0]  clk_post_cnt,
  output logic [7:0]  clk_trail_cnt
);

  typedef enum logic [2:0] {
    S_IDLE, S_RQST, S_BRDG, S_ZERO, S_SYNC, S_PAY, S_TRAIL, S_GAP
  } st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic           pend;
  logic           last_bit;
  logic [31:0]    sh_entry, sh_clk, sh_burst;
  logic           done;

  function automatic logic [CW-1:0] ld(input logic [7:0] f);
    return (f == 8'd0) ? '0 : CW'(f - 8'd1);
  endfunction

  assign done = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      pend     <= 1'b0;
      last_bit <= 1'b0;
      sh_entry <= '0;
      sh_clk   <= '0;
      sh_burst <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          sh_entry <= tim_entry;
          sh_clk   <= tim_clk;
          sh_burst <= tim_burst;
          if (req || pend) begin
            st   <= S_RQST;
            cnt  <= ld({4'd0, tim_entry[11:8]});
            pend <= 1'b0;
          end
        end
        S_RQST:
          if (done) begin st <= S_BRDG; cnt <= ld(sh_burst[7:0]); end
          else cnt <= cnt - 1'b1;
        S_BRDG:
          if (done) begin st <= S_ZERO; cnt <= ld(sh_burst[15:8]); end
          else cnt <= cnt - 1'b1;
        S_ZERO:
          if (done) st <= S_SYNC;
          else cnt <= cnt - 1'b1;
        S_SYNC: st <= S_PAY;
        S_PAY:
          if (tx_last) begin
            st       <= S_TRAIL;
            last_bit <= tx_data[7];
            cnt      <= ld({4'd0, sh_burst[19:16]});
          end
        S_TRAIL:
          if (done) begin st <= S_GAP; cnt <= ld(sh_entry[7:0]); end
          else cnt <= cnt - 1'b1;
        S_GAP: begin
          if (req) pend <= 1'b1;
          if (done) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign lp_p     = (st == S_IDLE) || (st == S_GAP);
  assign lp_n     = (st == S_IDLE) || (st == S_GAP) || (st == S_RQST);
  assign hs_en    = (st == S_ZERO) || (st == S_SYNC) || (st == S_PAY) || (st == S_TRAIL);
  assign tx_ready = (st == S_PAY);

  always_comb begin
    case (st)
      S_SYNC:  hs_byte = SYNC_BYTE;
      S_PAY:   hs_byte = tx_data;
      S_TRAIL: hs_byte = {8{~last_bit}};
      default: hs_byte = 8'h00;
    endcase
  end

  assign clk_prep_cnt  = sh_clk[31:24];
  assign clk_zero_cnt  = sh_clk[23:16];
  assign clk_post_cnt  = sh_clk[15:8];
  assign clk_trail_cnt = sh_clk[7:0];

endmodule

// File: rtl/hs_lane_seq_chk.sv
module hs_lane_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lp_p,
  input logic       lp_n,
  input logic       hs_en,
  input logic       tx_ready,
  input logic [7:0] clk_prep_cnt,
  input logic [7:0] clk_zero_cnt,
  input logic [7:0] clk_post_cnt,
  input logic [7:0] clk_trail_cnt
);

  // R1
  no_illegal_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lp_p && !lp_n));

  // R2
  lp01_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_p && lp_n) |-> ($past(lp_n) && !$past(hs_en)));

  // R2
  lp00_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_p && !lp_n && !hs_en) |-> !$past(lp_p));

  // R2
  hs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> ($past(!lp_p) && $past(!lp_n)));

  // R6
  ready_in_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (hs_en && !lp_p && !lp_n));

  // R8
  hs_exit_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_en) |-> (lp_p && lp_n));

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_p || hs_en) |=> $stable({clk_prep_cnt, clk_zero_cnt, clk_post_cnt, clk_trail_cnt}));

endmodule

bind hs_lane_seq hs_lane_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lp_p(lp_p), .lp_n(lp_n), .hs_en(hs_en),
  .tx_ready(tx_ready), .clk_prep_cnt(clk_prep_cnt), .clk_zero_cnt(clk_zero_cnt),
  .clk_post_cnt(clk_post_cnt), .clk_trail_cnt(clk_trail_cnt)
);

// File: tb/tb_hs_lane_seq.sv
`timescale 1ns/1ps
module tb_hs_lane_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] te, tc, tw;
  logic req = 1'b0, tx_last = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic lp_p, lp_n, hs_en, tx_ready;
  logic [7:0] hs_byte, cpp, czr, cps, ctr;

  int checks = 0, errors = 0;
  int n01, n00, nz, nsync, npay, ntr;
  bit order_bad, pay_bad, trail_bad;

  always #2.5 clk = ~clk;

  hs_lane_seq dut (
    .clk(clk), .rst_n(rst_n), .tim_entry(te), .tim_clk(tc), .tim_burst(tw),
    .req(req), .tx_data(tx_data), .tx_last(tx_last), .lp_p(lp_p), .lp_n(lp_n),
    .hs_en(hs_en), .hs_byte(hs_byte), .tx_ready(tx_ready), .clk_prep_cnt(cpp),
    .clk_zero_cnt(czr), .clk_post_cnt(cps), .clk_trail_cnt(ctr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic burst(input int nb, input logic [7:0] seed, input bit start, input bit poke,
                       input logic [31:0] ne, input logic [31:0] nc, input logic [31:0] nw);
    int ph, idx;
    bit clr, fin;
    logic [7:0] lastbyte;
    ph = start ? 0 : 1; n01 = start ? 0 : 1;
    n00 = 0; nz = 0; nsync = 0; npay = 0; ntr = 0; idx = 0;
    order_bad = 0; pay_bad = 0; trail_bad = 0; clr = 0; fin = 0; lastbyte = 8'h00;
    if (start) begin @(negedge clk); req = 1'b1; end
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (clr) begin req = 1'b0; clr = 0; end
      if (lp_p && lp_n && !hs_en) begin
        if (ph >= 6) begin fin = 1; break; end
        if (ph != 0) order_bad = 1;
      end else if (!lp_p && lp_n && !hs_en) begin
        if (ph > 1) order_bad = 1;
        ph = 1; n01++; req = 1'b0;
      end else if (!lp_p && !lp_n && !hs_en) begin
        if (ph < 1 || ph > 2) order_bad = 1;
        ph = 2; n00++;
      end else if (tx_ready) begin
        if (ph < 4) order_bad = 1;
        ph = 5;
        tx_data = seed + 8'(idx);
        tx_last = (idx == nb - 1);
        lastbyte = tx_data;
        #1;
        if (hs_byte !== tx_data) pay_bad = 1;
        idx++; npay++;
        if (poke && idx == 1) begin req = 1'b1; clr = 1; te = ne; tc = nc; tw = nw; end
      end else if (hs_en && ph >= 5) begin
        ph = 6; ntr++; tx_last = 1'b0;
        if (hs_byte !== {8{~lastbyte[7]}}) trail_bad = 1;
      end else if (hs_en && hs_byte == 8'hB8 && ph == 3) begin
        ph = 4; nsync++;
      end else if (hs_en && hs_byte == 8'h00 && (ph == 2 || ph == 3)) begin
        ph = 3; nz++;
      end else order_bad = 1;
    end
    if (!fin) order_bad = 1;
  endtask

  task automatic gap_then_req(output int g);
    g = 1;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 600; i++) begin
      if (!lp_p && lp_n) break;
      g++;
      @(negedge clk);
    end
  endtask

  task automatic settle(output int starts);
    starts = 0;
    repeat (300) begin
      @(negedge clk);
      if (!lp_p && lp_n) starts++;
    end
  endtask

  task automatic t_reset;
    chk(lp_p === 1'b1 && lp_n === 1'b1, "R1 idle lines", {lp_p, lp_n}, 3);
    chk(hs_en === 1'b0 && tx_ready === 1'b0, "R1 hs_en/ready low", {hs_en, tx_ready}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(lp_p && lp_n && !hs_en, "R1 idle after reset", {lp_p, lp_n, hs_en}, 6);
    chk(cpp == 8'h03 && czr == 8'h11, "R10 clock prepare/zero", {cpp, czr}, 16'h0311);
    chk(cps == 8'h0A && ctr == 8'h04, "R10 clock post/trail", {cps, ctr}, 16'h0A04);
  endtask

  task automatic t_compliant;
    int g, s;
    burst(4, 8'h10, 1, 0, '0, '0, '0);
    chk(!order_bad, "R2 state order", order_bad, 0);
    chk(n01 == 3, "R3 LP-01 length", n01, 3);
    chk(n00 == 3, "R4 LP-00 length", n00, 3);
    chk(nz == 10, "R4 zero length", nz, 10);
    chk(nsync == 1 && npay == 4 && !pay_bad, "R6 sync and payload", npay, 4);
    chk(ntr == 4 && !trail_bad, "R7 trailer FF", ntr, 4);
    gap_then_req(g);
    chk(g == 7, "R8 held request gap", g, 7);
    burst(1, 8'h81, 0, 0, '0, '0, '0);
    chk(!order_bad && n01 == 3, "R2 second burst order", n01, 3);
    chk(ntr == 4 && !trail_bad, "R7 trailer 00 after bit7=1", ntr, 4);
    settle(s);
  endtask

  task automatic t_zero_fields;
    int g, s;
    te = 32'h0; tw = 32'h0;
    settle(s);
    burst(2, 8'h40, 1, 0, '0, '0, '0);
    chk(!order_bad, "R2 order with zero fields", order_bad, 0);
    chk(n01 == 1 && n00 == 1, "R5 LP states one cycle", n01 * 10 + n00, 11);
    chk(nz == 1 && ntr == 1, "R5 zero/trailer one cycle", nz * 10 + ntr, 11);
    gap_then_req(g);
    chk(g == 2, "R5 R8 zero exit gap", g, 2);
    burst(1, 8'h05, 0, 0, '0, '0, '0);
    settle(s);
  endtask

  task automatic t_shadow;
    int s;
    te = 32'h0000_0402; tw = 32'h0002_0305; tc = 32'h0311_0A04;
    settle(s);
    burst(3, 8'h20, 1, 1, 32'h0000_0101, 32'h0102_0304, 32'h0006_0102);
    chk(n01 == 4 && n00 == 5 && nz == 3, "R3 R4 lengths before write", n01 * 100 + n00 * 10 + nz, 453);
    chk(ntr == 2, "R9 trailer keeps old value", ntr, 2);
    chk(cpp == 8'h03, "R9 clock field unchanged mid-sequence", cpp, 3);
    settle(s);
    chk(s == 0, "R11 request during payload ignored", s, 0);
    chk(cpp == 8'h01 && ctr == 8'h04, "R10 new clock fields", {cpp, ctr}, 16'h0104);
    burst(2, 8'h30, 1, 0, '0, '0, '0);
    chk(n01 == 1 && n00 == 2 && nz == 1 && ntr == 6, "R9 new values next burst",
        n01 * 1000 + n00 * 100 + nz * 10 + ntr, 1216);
    settle(s);
  endtask

  initial begin
    te = 32'h0000_0306; tc = 32'h0311_0A04; tw = 32'h0004_0A03;
    repeat (3) @(negedge clk);
    t_reset;
    t_compliant;
    t_zero_fields;
    t_shadow;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500us;
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule